// File: doc/BRIEF.md
# Single-wire debug wake-up detector

This block watches an open-drain debug line after power-on and decides when a host tool wants to take control of it. Until that happens the interface is OFF. A host announces itself by holding the line low for a minimum time. It then sends a burst of four slow pulses followed by four pulses at twice that rate. The block measures every pulse period on a divided slow time base. It accepts the pattern when the slow periods are about twice the mean fast period, whatever the absolute rate, so an untrimmed RC oscillator does not matter. On acceptance the interface becomes ACTIVE and the block answers by pulling the line low for a fixed number of fast-clock cycles. This answer is the synchronization frame.

Software can claim the pin as a general-purpose I/O at any time before the host gets in. Once the link is ACTIVE such a claim is ignored. While ACTIVE, the host can hold the line low for longer than a threshold. The block treats this as a link reset: it emits a one-cycle request to fall back to the low-speed bit format and sends the synchronization frame again. Bit-level traffic is handled elsewhere.

Top module: `swd_wake_detect`

## Requirements
- R1: After reset, mode_o is OFF, and pull_low_o and force_ls_o are low. The mode encoding is 2'b00 OFF, 2'b01 ACTIVE and 2'b10 I/O. 2'b11 never appears.
- R2: In OFF, the search arms only on a rising edge that ends a low of at least ENTRY_LOW fast-clock cycles. A low one cycle shorter does not arm it.
- R3: Once armed, the block times eight periods, each from one rising edge to the next. At the eighth rising edge it becomes ACTIVE if the ratio test of R4 passes.
- R4: Periods are counted in slow ticks, where one tick is SLOW_DIV fast cycles. Each of the first four periods P must satisfy 3*S <= 8*P <= 5*S, where S is the sum of the last four periods. A pattern with both bursts scaled by the same factor is accepted. A pattern with any slow period outside the band leaves the block OFF and disarms the search.
- R5: A GPIO request while OFF moves the block to I/O. It stays in I/O until reset, and an entry pattern then causes neither a mode change nor a pull-down.
- R6: A GPIO request while ACTIVE has no effect: the mode stays ACTIVE and link resets still work.
- R7: In the first cycle of ACTIVE, pull_low_o rises and stays high for exactly SYNC_LEN cycles.
- R8: While ACTIVE, a low longer than RESET_LOW fast cycles produces a one-cycle force_ls_o at the rising edge that ends it. A new SYNC_LEN-cycle pull-down starts in the same cycle. A low of RESET_LOW cycles or less does nothing.
- R9: Reset returns the block to OFF from ACTIVE and from I/O.
- R10: The line seen low because of the block's own pull-down is never counted as a host low. No link reset follows a synchronization frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock; the slow tick is divided from it |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Sampled level of the open-drain debug line |
| gpio_req_i | input | 1 | Software request to hand the pin to general-purpose I/O |
| mode_o | output | 2 | Interface mode: 00 OFF, 01 ACTIVE, 10 I/O |
| pull_low_o | output | 1 | Enables the pin pull-down during a synchronization frame |
| force_ls_o | output | 1 | One-cycle request to reset the link to low-speed format |

## Verification
The bench builds the block with SLOW_DIV=4 and PER_W=10, and keeps ENTRY_LOW=64, RESET_LOW=64 and SYNC_LEN=128. With these values a slow tick is four fast cycles, so a full entry pattern takes about 1.6k cycles. That makes it practical to run nominal, rescaled, out-of-band-high, out-of-band-low and in-band-skewed patterns. The short tick leaves quantization error of one tick against slow periods of 64 ticks, far inside the ±25 % band. The default thresholds keep the boundaries exact: 63 against 64 low cycles for arming, and 64 against 65 for link reset.

// File: rtl/swd_wake_detect.sv
module swd_wake_detect #(
  parameter int SLOW_DIV  = 32,
  parameter int ENTRY_LOW = 64,
  parameter int RESET_LOW = 64,
  parameter int SYNC_LEN  = 128,
  parameter int PER_W     = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic       gpio_req_i,
  output logic [1:0] mode_o,
  output logic       pull_low_o,
  output logic       force_ls_o
);

  localparam int LOW_LIM = ((ENTRY_LOW > RESET_LOW) ? ENTRY_LOW : RESET_LOW) + 1;
  localparam int LOW_W   = $clog2(LOW_LIM + 1);
  localparam int DIV_W   = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam int SYNC_W  = $clog2(SYNC_LEN + 1);
  localparam int SUM_W   = PER_W + 2;
  localparam int CMP_W   = PER_W + 5;
  localparam int GUARD   = 4;

  localparam logic [1:0] M_OFF    = 2'b00;
  localparam logic [1:0] M_ACTIVE = 2'b01;
  localparam logic [1:0] M_IO     = 2'b10;

  logic              sync1, pin_s, pin_d;
  logic [DIV_W-1:0]  div_cnt;
  logic              tick;
  logic [LOW_W-1:0]  low_cnt;
  logic [PER_W-1:0]  per_cnt;
  logic [PER_W-1:0]  slow_per [4];
  logic [SUM_W-1:0]  fast_sum;
  logic              armed;
  logic [2:0]        idx;
  logic [1:0]        mode;
  logic [SYNC_W-1:0] sync_cnt;
  logic [2:0]        guard_cnt;
  logic              force_q;
  logic [CMP_W-1:0]  span_sum;
  logic [3:0]        in_band;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) {sync1, pin_s, pin_d} <= 3'b111;
    else begin
      sync1 <= pin_i;
      pin_s <= sync1;
      pin_d <= pin_s;
    end

  wire rise  = pin_s & ~pin_d;
  wire quiet = (sync_cnt != '0) || (guard_cnt != '0);

  assign tick = (div_cnt == DIV_W'(SLOW_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   div_cnt <= '0;
    else if (tick) div_cnt <= '0;
    else           div_cnt <= div_cnt + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                                  low_cnt <= '0;
    else if (pin_s || quiet)                      low_cnt <= '0;
    else if (low_cnt != LOW_W'(LOW_LIM))          low_cnt <= low_cnt + 1'b1;

  assign span_sum = CMP_W'(fast_sum) + CMP_W'(per_cnt);

  for (genvar g = 0; g < 4; g++) begin : g_band
    wire [CMP_W-1:0] scaled = CMP_W'(slow_per[g]) << 3;
    assign in_band[g] = (scaled >= CMP_W'(3) * span_sum) &&
                        (scaled <= CMP_W'(5) * span_sum);
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      mode      <= M_OFF;
      armed     <= 1'b0;
      idx       <= '0;
      per_cnt   <= '0;
      fast_sum  <= '0;
      for (int i = 0; i < 4; i++) slow_per[i] <= '0;
      sync_cnt  <= '0;
      guard_cnt <= '0;
      force_q   <= 1'b0;
    end else begin
      force_q <= 1'b0;
      if (sync_cnt != '0) begin
        sync_cnt <= sync_cnt - 1'b1;
        if (sync_cnt == SYNC_W'(1)) guard_cnt <= 3'(GUARD);
      end else if (guard_cnt != '0) begin
        guard_cnt <= guard_cnt - 1'b1;
      end
      if (tick && per_cnt != '1) per_cnt <= per_cnt + 1'b1;

      case (mode)
        M_OFF:
          if (gpio_req_i) mode <= M_IO;
          else if (rise) begin
            per_cnt <= '0;
            if (!armed) begin
              if (low_cnt >= LOW_W'(ENTRY_LOW)) begin
                armed    <= 1'b1;
                idx      <= '0;
                fast_sum <= '0;
              end
            end else begin
              idx <= idx + 1'b1;
              if (!idx[2])           slow_per[idx[1:0]] <= per_cnt;
              else if (idx != 3'd7)  fast_sum <= fast_sum + SUM_W'(per_cnt);
              else begin
                armed <= 1'b0;
                if (&in_band) begin
                  mode     <= M_ACTIVE;
                  sync_cnt <= SYNC_W'(SYNC_LEN);
                end
              end
            end
          end
        M_ACTIVE:
          if (rise && !quiet && low_cnt > LOW_W'(RESET_LOW)) begin
            force_q  <= 1'b1;
            sync_cnt <= SYNC_W'(SYNC_LEN);
          end
        default: ;
      endcase
    end

  assign mode_o     = mode;
  assign pull_low_o = (sync_cnt != '0);
  assign force_ls_o = force_q;

endmodule

// File: rtl/swd_wake_detect_chk.sv
module swd_wake_detect_chk #(
  parameter int SYNC_LEN = 128
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_o,
  input logic       pull_low_o,
  input logic       force_ls_o
);

  logic [15:0] run;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)         run <= '0;
    else if (pull_low_o) run <= run + 1'b1;
    else                 run <= '0;

  p_reset_off_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (mode_o == 2'b00 && !pull_low_o && !force_ls_o));

  p_mode_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'b11);

  p_io_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 2'b10 |=> mode_o == 2'b10);

  p_active_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 2'b01 |=> mode_o == 2'b01);

  p_entry_sync_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_o == 2'b01) |-> pull_low_o);

  p_sync_width_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pull_low_o) |-> run == 16'(SYNC_LEN));

  p_force_active_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_ls_o |-> (mode_o == 2'b01 && pull_low_o));

  p_force_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_ls_o |=> !force_ls_o);

endmodule

bind swd_wake_detect swd_wake_detect_chk #(.SYNC_LEN(SYNC_LEN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_o     (mode_o),
  .pull_low_o (pull_low_o),
  .force_ls_o (force_ls_o)
);

// File: tb/test_swd_wake_detect.sv
module test_swd_wake_detect;

  localparam int SYNC = 128;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host = 1'b1;
  logic       gpio = 1'b0;
  logic       pin;
  logic [1:0] mode;
  logic       pull, force_ls;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { int kind; int width; string req; } item_t;
  item_t exp_q[$];

  always #2.5 clk = ~clk;

  assign pin = host & ~pull;

  swd_wake_detect #(.SLOW_DIV(4), .PER_W(10)) i_swd_wake_detect (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .gpio_req_i(gpio),
    .mode_o(mode), .pull_low_o(pull), .force_ls_o(force_ls));

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic void take(int kind, int w);
    item_t it;
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL R10 unexpected event kind %0d width %0d: actual 1 expected 0", kind, w);
      return;
    end
    it = exp_q.pop_front();
    if (it.kind != kind || (kind == 0 && it.width != w)) begin
      errors++;
      $display("FAIL %s event kind/width: actual %0d/%0d expected %0d/%0d",
               it.req, kind, w, it.kind, it.width);
    end
  endfunction

  // monitor: sync frames (kind 0) and force pulses (kind 1)
  int  run = 0;
  logic pull_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (force_ls) take(1, 0);
      if (pull) run++;
      else if (pull_prev) begin take(0, run); run = 0; end
    end else run = 0;
    pull_prev = rst_n && pull;
  end

  task automatic drive(logic v, int n);
    host = v;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pattern(int lowlen, int ps, int pf, int odd_p, int odd_i);
    drive(1'b0, lowlen);
    for (int i = 0; i < 8; i++) begin
      int p = (i < 4) ? ps : pf;
      if (i == odd_i) p = odd_p;
      drive(1'b1, p / 2);
      drive(1'b0, p / 2);
    end
    drive(1'b1, 300);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    host  = 1'b1;
    gpio  = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    drive(1'b1, 4);
  endtask

  task automatic push(int kind, string req);
    item_t it;
    it.kind = kind; it.width = SYNC; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic expect_mode(logic [1:0] m, string req, string what);
    @(negedge clk);
    chk(mode == m, req, what, int'(mode), int'(m));
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(mode == 2'b00 && !pull && !force_ls, "R1", "reset outputs", int'({mode, pull, force_ls}), 0);
    do_reset();
    expect_mode(2'b00, "R1", "mode after reset release");

    // R2/R3/R7: nominal pattern, minimum entry low
    push(0, "R7");
    pattern(64, 256, 128, 0, -1);
    expect_mode(2'b01, "R3", "nominal entry");

    // R6: GPIO request ignored when ACTIVE
    gpio = 1'b1; drive(1'b1, 10); gpio = 1'b0;
    expect_mode(2'b01, "R6", "gpio in active");

    // R8: boundary lows
    drive(1'b0, 20); drive(1'b1, 50);
    drive(1'b0, 64); drive(1'b1, 300);
    push(1, "R8"); push(0, "R8");
    drive(1'b0, 65); drive(1'b1, 300);
    push(1, "R8"); push(0, "R8");
    drive(1'b0, 500); drive(1'b1, 300);
    expect_mode(2'b01, "R8", "mode after link resets");

    // R9: reset from ACTIVE
    do_reset();
    expect_mode(2'b00, "R9", "reset from active");

    // R4: scaled pattern accepted
    push(0, "R4");
    pattern(100, 128, 64, 0, -1);
    expect_mode(2'b01, "R4", "half-scale pattern");
    do_reset();

    // R4: slow period too long
    pattern(100, 256, 128, 384, 2);
    expect_mode(2'b00, "R4", "slow period above band");
    do_reset();

    // R4: slow period too short
    pattern(100, 256, 128, 160, 0);
    expect_mode(2'b00, "R4", "slow period below band");
    do_reset();

    // R4: skewed but in band
    push(0, "R4");
    pattern(100, 256, 128, 288, 3);
    expect_mode(2'b01, "R4", "slow period inside band");
    do_reset();

    // R2: entry low one short
    pattern(63, 256, 128, 0, -1);
    expect_mode(2'b00, "R2", "entry low of 63");
    do_reset();

    // R5: GPIO before entry, then pattern ignored
    gpio = 1'b1; drive(1'b1, 2); gpio = 1'b0;
    expect_mode(2'b10, "R5", "gpio in off");
    pattern(100, 256, 128, 0, -1);
    expect_mode(2'b10, "R5", "pattern while in io");

    do_reset();
    expect_mode(2'b00, "R9", "reset from io");

    drive(1'b1, 50);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s missing events: actual %0d expected 0", exp_q[0].req, exp_q.size());
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule